// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block gives a host a way into a narrow downstream register bus through three 64-bit registers in a memory-mapped window. The host stages a 32-bit value in a write-data register, then writes a command register holding a downstream word index together with a write or read request bit. The bridge starts one access on a request/acknowledge bus, keeps the request bit set while that access is outstanding, and clears the bit itself once the downstream side acknowledges.

The host learns that the access has finished only by polling the request bit. For a read, the returned word then sits in the low 32 bits of a read-data register. The host converts a downstream byte address into a word index (byte address divided by four) before writing the command. Bit 32 of the read-data register is a host-writable debug flag. It is kept apart from the captured data.

Window offsets are 0x10 for the command register, 0x18 for read data and 0x20 for write data. Every other offset is unmapped.

Top module: `ind_reg_bridge`

## Requirements
- R1: After reset, ds_req and busy are 0. Reads of the command, read-data and write-data registers return 0.
- R2: Writing the command register while idle with bit 8 set starts a write. After that clock edge, ds_req=1, ds_we=1, ds_addr holds command bits [IDX_W-1:0], and ds_wdata holds the value staged earlier in write-data bits 31:0.
- R3: Writing the command register while idle with bit 9 set and bit 8 clear starts a read. After that edge, ds_req=1, ds_we=0 and ds_addr holds the index.
- R4: While no ds_ack arrives, ds_req, ds_we, ds_addr and ds_wdata hold their values. The request bit in the command register stays set, and busy stays 1.
- R5: On the edge where ds_ack=1 with ds_req=1, ds_req and busy fall and the request bit clears. For a read, ds_rdata from that cycle appears in read-data bits 31:0.
- R6: A command write that arrives while an access is pending is ignored. The pending index, the request bits and the downstream signals are unchanged.
- R7: A read of the command register returns the stored index in bits [IDX_W-1:0], the live write request in bit 8 and the live read request in bit 9. All other bits read 0.
- R8: Writes to unmapped offsets are ignored, and reads of unmapped offsets return 0.
- R9: A command with both bit 8 and bit 9 set performs a write, and only bit 8 reads back as pending.
- R10: Only bits 31:0 of the write-data register are kept; its upper bits read 0. A host write to the read-data register changes only the debug flag in bit 32, and bits 31:0 are not host-writable.
- R11: A ds_ack while no access is pending has no effect. ds_req stays 0, and the read-data register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_addr | input | HADDR_W | Host byte offset within the window |
| h_wdata | input | 64 | Host write data |
| h_rdata | output | 64 | Host read data, registered |
| ds_req | output | 1 | Downstream request, held until ack |
| ds_we | output | 1 | Downstream write enable (1 = write) |
| ds_addr | output | IDX_W | Downstream word index |
| ds_wdata | output | DW | Downstream write data |
| ds_rdata | input | DW | Downstream read data, valid in the ack cycle |
| ds_ack | input | 1 | Single-cycle downstream acknowledge |
| busy | output | 1 | An access is pending |

## Verification
A command write changes ds_req, ds_we, ds_addr and ds_wdata on the same edge that samples it, so the bench checks those signals at the falling edge that follows. The ds_ack edge clears ds_req and busy at once, so these are also checked half a cycle later. Host reads are registered. Each register check therefore issues the read, waits one edge, and compares h_rdata at the next falling edge. Register state after an ack or an ignored command is checked only with such a read, taken after the edge that could have changed it.

// File: rtl/ind_bridge_pkg.sv
package ind_bridge_pkg;
  localparam int OFS_CMD   = 'h10;
  localparam int OFS_RDATA = 'h18;
  localparam int OFS_WDATA = 'h20;
  localparam int BIT_WR    = 8;
  localparam int BIT_RD    = 9;
  localparam int BIT_DBG   = 32;
  localparam int HOST_DW   = 64;
  localparam int CMD_W     = 10;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WR   = 2'd1,
    ST_RD   = 2'd2
  } op_e;
endpackage

// File: rtl/ind_cmd_engine.sv
module ind_cmd_engine
  import ind_bridge_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd_data,
  input  logic [DW-1:0]    stage_wdata,
  input  logic             ds_ack,
  input  logic [DW-1:0]    ds_rdata,
  output logic             ds_req,
  output logic             ds_we,
  output logic [IDX_W-1:0] ds_addr,
  output logic [DW-1:0]    ds_wdata,
  output logic [IDX_W-1:0] cur_idx,
  output logic             wr_pend,
  output logic             rd_pend,
  output logic [DW-1:0]    rd_word
);
  op_e st;

  assign wr_pend = (st == ST_WR);
  assign rd_pend = (st == ST_RD);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      ds_req   <= 1'b0;
      ds_we    <= 1'b0;
      ds_addr  <= '0;
      ds_wdata <= '0;
      cur_idx  <= '0;
      rd_word  <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (cmd_we) begin
            cur_idx <= cmd_data[IDX_W-1:0];
            if (cmd_data[BIT_WR]) begin
              st       <= ST_WR;
              ds_req   <= 1'b1;
              ds_we    <= 1'b1;
              ds_addr  <= cmd_data[IDX_W-1:0];
              ds_wdata <= stage_wdata;
            end else if (cmd_data[BIT_RD]) begin
              st      <= ST_RD;
              ds_req  <= 1'b1;
              ds_we   <= 1'b0;
              ds_addr <= cmd_data[IDX_W-1:0];
            end
          end
        end
        default: begin
          if (ds_ack) begin
            st     <= ST_IDLE;
            ds_req <= 1'b0;
            if (st == ST_RD) rd_word <= ds_rdata;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/ind_host_regs.sv
module ind_host_regs
  import ind_bridge_pkg::*;
#(
  parameter int HADDR_W = 6,
  parameter int IDX_W   = 8,
  parameter int DW      = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               h_wr,
  input  logic               h_rd,
  input  logic [HADDR_W-1:0] h_addr,
  input  logic [HOST_DW-1:0] h_wdata,
  output logic [HOST_DW-1:0] h_rdata,
  input  logic [IDX_W-1:0]   cur_idx,
  input  logic               wr_pend,
  input  logic               rd_pend,
  input  logic [DW-1:0]      rd_word,
  output logic               cmd_we,
  output logic [CMD_W-1:0]   cmd_data,
  output logic [DW-1:0]      stage_wdata
);
  localparam logic [HADDR_W-1:0] A_CMD = HADDR_W'(OFS_CMD);
  localparam logic [HADDR_W-1:0] A_RD  = HADDR_W'(OFS_RDATA);
  localparam logic [HADDR_W-1:0] A_WD  = HADDR_W'(OFS_WDATA);

  logic               dbg_flag;
  logic [HOST_DW-1:0] rd_mux;

  assign cmd_we   = h_wr && (h_addr == A_CMD);
  assign cmd_data = h_wdata[CMD_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_wdata <= '0;
      dbg_flag    <= 1'b0;
    end else if (h_wr) begin
      if (h_addr == A_WD) stage_wdata <= h_wdata[DW-1:0];
      if (h_addr == A_RD) dbg_flag    <= h_wdata[BIT_DBG];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (h_addr == A_CMD) begin
      rd_mux[IDX_W-1:0] = cur_idx;
      rd_mux[BIT_WR]    = wr_pend;
      rd_mux[BIT_RD]    = rd_pend;
    end else if (h_addr == A_RD) begin
      rd_mux[DW-1:0]    = rd_word;
      rd_mux[BIT_DBG]   = dbg_flag;
    end else if (h_addr == A_WD) begin
      rd_mux[DW-1:0]    = stage_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       h_rdata <= '0;
    else if (h_rd) h_rdata <= rd_mux;
  end
endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge
  import ind_bridge_pkg::*;
#(
  parameter int HADDR_W = 6,
  parameter int IDX_W   = 8,
  parameter int DW      = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               h_wr,
  input  logic               h_rd,
  input  logic [HADDR_W-1:0] h_addr,
  input  logic [63:0]        h_wdata,
  output logic [63:0]        h_rdata,
  output logic               ds_req,
  output logic               ds_we,
  output logic [IDX_W-1:0]   ds_addr,
  output logic [DW-1:0]      ds_wdata,
  input  logic [DW-1:0]      ds_rdata,
  input  logic               ds_ack,
  output logic               busy
);
  if (IDX_W > BIT_WR) begin : g_idx_chk
    $error("IDX_W must fit below the request bits");
  end
  if (DW > BIT_DBG) begin : g_dw_chk
    $error("DW must fit below the debug flag");
  end

  logic             cmd_we;
  logic [CMD_W-1:0] cmd_data;
  logic [DW-1:0]    stage_wdata;
  logic [IDX_W-1:0] cur_idx;
  logic             wr_pend;
  logic             rd_pend;
  logic [DW-1:0]    rd_word;

  assign busy = wr_pend | rd_pend;

  ind_host_regs #(.HADDR_W(HADDR_W), .IDX_W(IDX_W), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .cur_idx(cur_idx),
    .wr_pend(wr_pend), .rd_pend(rd_pend), .rd_word(rd_word),
    .cmd_we(cmd_we), .cmd_data(cmd_data), .stage_wdata(stage_wdata)
  );

  ind_cmd_engine #(.IDX_W(IDX_W), .DW(DW)) u_eng (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_data(cmd_data),
    .stage_wdata(stage_wdata), .ds_ack(ds_ack), .ds_rdata(ds_rdata),
    .ds_req(ds_req), .ds_we(ds_we), .ds_addr(ds_addr), .ds_wdata(ds_wdata),
    .cur_idx(cur_idx), .wr_pend(wr_pend), .rd_pend(rd_pend), .rd_word(rd_word)
  );
endmodule

// File: rtl/ind_bridge_chk.sv
module ind_bridge_chk
  import ind_bridge_pkg::*;
#(
  parameter int HADDR_W = 6,
  parameter int IDX_W   = 8,
  parameter int DW      = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               h_wr,
  input logic [HADDR_W-1:0] h_addr,
  input logic [63:0]        h_wdata,
  input logic               ds_req,
  input logic               ds_we,
  input logic [IDX_W-1:0]   ds_addr,
  input logic [DW-1:0]      ds_wdata,
  input logic               ds_ack,
  input logic               busy
);
  logic host_cmd;
  assign host_cmd = h_wr && (h_addr == HADDR_W'(OFS_CMD));

  p_start_wr_r2: assert property (@(posedge clk) disable iff (rst)
    (!ds_req && host_cmd && h_wdata[BIT_WR]) |=> (ds_req && ds_we));

  p_start_rd_r3: assert property (@(posedge clk) disable iff (rst)
    (!ds_req && host_cmd && h_wdata[BIT_RD] && !h_wdata[BIT_WR]) |=> (ds_req && !ds_we));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (ds_req && !ds_ack) |=> (ds_req && $stable(ds_we) && $stable(ds_addr) && $stable(ds_wdata)));

  p_busy_req_r4: assert property (@(posedge clk) disable iff (rst)
    busy == ds_req);

  p_ack_drop_r5: assert property (@(posedge clk) disable iff (rst)
    (ds_req && ds_ack) |=> !ds_req);

  p_idle_stays_r11: assert property (@(posedge clk) disable iff (rst)
    (!ds_req && !host_cmd) |=> !ds_req);
endmodule

bind ind_reg_bridge ind_bridge_chk #(.HADDR_W(HADDR_W), .IDX_W(IDX_W), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata),
  .ds_req(ds_req), .ds_we(ds_we), .ds_addr(ds_addr), .ds_wdata(ds_wdata),
  .ds_ack(ds_ack), .busy(busy)
);

// File: tb/ind_reg_bridge_tb.sv
module ind_reg_bridge_tb;
  localparam int HADDR_W = 6;
  localparam int IDX_W   = 8;
  localparam int DW      = 32;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               h_wr = 1'b0;
  logic               h_rd = 1'b0;
  logic [HADDR_W-1:0] h_addr = '0;
  logic [63:0]        h_wdata = '0;
  logic [63:0]        h_rdata;
  logic               ds_req;
  logic               ds_we;
  logic [IDX_W-1:0]   ds_addr;
  logic [DW-1:0]      ds_wdata;
  logic [DW-1:0]      ds_rdata = '0;
  logic               ds_ack = 1'b0;
  logic               busy;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  ind_reg_bridge #(.HADDR_W(HADDR_W), .IDX_W(IDX_W), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .ds_req(ds_req), .ds_we(ds_we),
    .ds_addr(ds_addr), .ds_wdata(ds_wdata), .ds_rdata(ds_rdata),
    .ds_ack(ds_ack), .busy(busy)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      total = total + 1;
      bad   = bad + 1;
      $display("FAIL watchdog: run did not finish, act=%0d exp<=20000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [HADDR_W-1:0] a, input logic [63:0] d);
    @(negedge clk);
    h_wr = 1'b1; h_addr = a; h_wdata = d;
    @(posedge clk);
    @(negedge clk);
    h_wr = 1'b0;
  endtask

  task automatic hread(input logic [HADDR_W-1:0] a, output logic [63:0] d);
    @(negedge clk);
    h_rd = 1'b1; h_addr = a;
    @(posedge clk);
    @(negedge clk);
    h_rd = 1'b0;
    d = h_rdata;
  endtask

  task automatic ack(input logic [DW-1:0] v);
    @(negedge clk);
    ds_ack = 1'b1; ds_rdata = v;
    @(posedge clk);
    @(negedge clk);
    ds_ack = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [63:0] d;
    chk("R1 ds_req", 64'(ds_req), 64'd0);
    chk("R1 busy", 64'(busy), 64'd0);
    hread(6'h10, d); chk("R1 cmd", d, 64'd0);
    hread(6'h18, d); chk("R1 rdata", d, 64'd0);
    hread(6'h20, d); chk("R1 wdata", d, 64'd0);
  endtask

  task automatic t_write();
    logic [63:0] d;
    hwrite(6'h20, 64'hFFFF_FFFF_A5A5_1234);
    hread(6'h20, d); chk("R10 wdata upper bits", d, 64'h0000_0000_A5A5_1234);
    hwrite(6'h10, 64'h105);
    chk("R2 ds_req", 64'(ds_req), 64'd1);
    chk("R2 ds_we", 64'(ds_we), 64'd1);
    chk("R2 ds_addr", 64'(ds_addr), 64'd5);
    chk("R2 ds_wdata", 64'(ds_wdata), 64'hA5A5_1234);
    idle(3);
    chk("R4 req held", 64'(ds_req), 64'd1);
    chk("R4 busy", 64'(busy), 64'd1);
    hread(6'h10, d); chk("R7 R4 cmd pending", d, 64'h105);
    hwrite(6'h10, 64'h203);
    chk("R6 addr kept", 64'(ds_addr), 64'd5);
    chk("R6 we kept", 64'(ds_we), 64'd1);
    hread(6'h10, d); chk("R6 cmd unchanged", d, 64'h105);
    ack(32'h0BAD_0BAD);
    chk("R5 req drop", 64'(ds_req), 64'd0);
    chk("R5 busy drop", 64'(busy), 64'd0);
    hread(6'h10, d); chk("R5 R7 cmd cleared", d, 64'h005);
    hread(6'h18, d); chk("R5 write ack leaves rdata", d, 64'd0);
  endtask

  task automatic t_read();
    logic [63:0] d;
    hwrite(6'h10, 64'h206);
    chk("R3 ds_req", 64'(ds_req), 64'd1);
    chk("R3 ds_we", 64'(ds_we), 64'd0);
    chk("R3 ds_addr", 64'(ds_addr), 64'd6);
    hread(6'h10, d); chk("R7 read pending", d, 64'h206);
    ack(32'hDEAD_BEEF);
    chk("R5 read req drop", 64'(ds_req), 64'd0);
    hread(6'h10, d); chk("R5 read bit cleared", d, 64'h006);
    hread(6'h18, d); chk("R5 rdata captured", d, 64'h0000_0000_DEAD_BEEF);
  endtask

  task automatic t_both();
    logic [63:0] d;
    hwrite(6'h10, 64'h318);
    chk("R9 ds_we", 64'(ds_we), 64'd1);
    chk("R9 ds_addr", 64'(ds_addr), 64'h18);
    hread(6'h10, d); chk("R9 only write pending", d, 64'h118);
    ack(32'h7777_7777);
    hread(6'h18, d); chk("R9 rdata untouched", d, 64'h0000_0000_DEAD_BEEF);
  endtask

  task automatic t_debug();
    logic [63:0] d;
    hwrite(6'h18, 64'h0000_0001_1234_5678);
    hread(6'h18, d); chk("R10 dbg set, data kept", d, 64'h0000_0001_DEAD_BEEF);
  endtask

  task automatic t_unmapped();
    logic [63:0] d;
    hwrite(6'h08, 64'hFFFF_FFFF_FFFF_FFFF);
    hwrite(6'h28, 64'hFFFF_FFFF_FFFF_FFFF);
    hwrite(6'h11, 64'h0000_0000_0000_0107);
    chk("R8 no access started", 64'(ds_req), 64'd0);
    hread(6'h08, d); chk("R8 read 0x08", d, 64'd0);
    hread(6'h28, d); chk("R8 read 0x28", d, 64'd0);
    hread(6'h00, d); chk("R8 read 0x00", d, 64'd0);
    hread(6'h20, d); chk("R8 wdata kept", d, 64'h0000_0000_A5A5_1234);
    hread(6'h10, d); chk("R8 cmd kept", d, 64'h018);
  endtask

  task automatic t_idle_ack();
    logic [63:0] d;
    ack(32'h1111_1111);
    chk("R11 req stays low", 64'(ds_req), 64'd0);
    chk("R11 busy stays low", 64'(busy), 64'd0);
    hread(6'h18, d); chk("R11 rdata kept", d, 64'h0000_0001_DEAD_BEEF);
  endtask

  initial begin
    idle(3);
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_write();
    t_read();
    t_both();
    t_debug();
    t_unmapped();
    t_idle_ack();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule